// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit performs one-bit operations on a data word. Each request carries an operand, a bit number, an operand width (byte or longword) and an operation. The unit reads the selected bit, reports its prior state on a zero flag, and returns the operand with that bit left alone, forced high, forced low or flipped. It also raises a write-back enable whenever the operation changed the destination.

The bit number wraps to the chosen operand width. A longword uses all bit-number bits. A byte keeps only the low three, so every byte operation stays inside bits 7..0. The result is captured in an output register behind a valid/ready handshake. A stalled consumer holds the result steady and also back-pressures the producer. Address generation, memory access and all other condition flags belong to neighbouring blocks.

Top module: `bit_modify_unit`

## Requirements
- R1: Operation code 2'b00 (test) returns the operand unchanged on `out_result` and drives `out_wb_en` low.
- R2: For every operation, `out_zero` is 1 when the selected bit of the operand was 0 before modification, and 0 when it was 1.
- R3: Operation code 2'b11 (set) returns the operand with the selected bit forced to 1 and every other bit unchanged.
- R4: Operation code 2'b10 (clear) returns the operand with the selected bit forced to 0 and every other bit unchanged.
- R5: Operation code 2'b01 (change) returns the operand with the selected bit inverted and every other bit unchanged.
- R6: With `in_size_long` = 1 (longword), the selected bit is `in_bitnum` taken modulo 32, using all five bits.
- R7: With `in_size_long` = 0 (byte), the selected bit is `in_bitnum` modulo 8, and bits 31..8 of the result equal those of the operand.
- R8: `out_wb_en` is 1 for the change, clear and set operations.
- R9: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 after exactly that edge. `in_ready` equals `!out_valid || out_ready`. After an edge where `in_ready` is 1 and `in_valid` is 0, `out_valid` is 0.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_result`, `out_zero` and `out_wb_en` hold their values and `out_valid` stays 1.
- R11: While `rst_n` is low and until the first accepted request after its release, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_operand | input | 32 | Operand data |
| in_bitnum | input | 5 | Bit number before width wrap |
| in_size_long | input | 1 | 1 = longword, 0 = byte |
| in_op | input | 2 | 00 test, 01 change, 10 clear, 11 set |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Modified operand |
| out_zero | output | 1 | Inverse of the tested bit's prior value |
| out_wb_en | output | 1 | Destination must be written back |

## Verification
All results come from one register stage, so each result appears one rising edge after its request is accepted. The bench drives inputs on the falling edge and samples 1 ns after the accepting rising edge. During a stall it samples after several further edges to confirm the outputs have not moved. `in_ready` is combinational from the output state, so the bench checks it between edges. After `rst_n` rises, the reset synchronizer takes two edges, and the bench waits three edges before it issues the first request.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [1:0] {
    BMU_TEST = 2'b00,
    BMU_FLIP = 2'b01,
    BMU_CLR  = 2'b10,
    BMU_SET  = 2'b11
  } bmu_op_e;

endpackage

// File: rtl/bmu_rst_sync.sv
module bmu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/bmu_index.sv
module bmu_index #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int BIDX_W = $clog2(BYTE_W)
) (
  input  logic [IDX_W-1:0]  bitnum,
  input  logic              size_long,
  output logic [DATA_W-1:0] mask
);
  logic [IDX_W-1:0] idx;

  // Wrap the bit number to the operand width.
  always_comb begin
    if (size_long) idx = bitnum;
    else           idx = IDX_W'(bitnum[BIDX_W-1:0]);
  end

  // One-hot decode of the wrapped index.
  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign mask[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/bmu_alu.sv
module bmu_alu
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] mask,
  input  bmu_op_e           op,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              wb_en
);
  logic tested;

  always_comb begin
    tested = |(operand & mask);
    zero   = ~tested;
    wb_en  = (op != BMU_TEST);
    unique case (op)
      BMU_TEST: result = operand;
      BMU_FLIP: result = operand ^ mask;
      BMU_CLR:  result = operand & ~mask;
      BMU_SET:  result = operand | mask;
      default:  result = operand;
    endcase
  end

  // R3 R4 R5: never more than the selected bit differs.
  always_comb begin
    if (!$isunknown(operand) && !$isunknown(mask) && !$isunknown(op)) begin
      p_one_bit_r5: assert ($countones(result ^ operand) <= 1)
        else $error("more than one bit modified");
    end
  end
endmodule

// File: rtl/bmu_out_reg.sv
module bmu_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d_result,
  input  logic              d_zero,
  input  logic              d_wb_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_zero,
  output logic              out_wb_en
);
  logic              valid_q, valid_d;
  logic              load;
  logic [DATA_W-1:0] result_q;
  logic              zero_q, wb_q;

  always_comb begin
    in_ready = !valid_q || out_ready;
    load     = in_valid && in_ready;
    valid_d  = valid_q;
    if (in_ready) valid_d = in_valid;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) valid_q <= 1'b0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      result_q <= d_result;
      zero_q   <= d_zero;
      wb_q     <= d_wb_en;
    end
  end

  assign out_valid  = valid_q;
  assign out_result = result_q;
  assign out_zero   = zero_q;
  assign out_wb_en  = wb_q;

  p_accept_valid_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_ready) |=> out_valid)
    else $error("accepted request not presented");

  p_idle_drop_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (!in_valid && in_ready) |=> !out_valid)
    else $error("stale valid after idle");

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_zero) && $stable(out_wb_en)))
    else $error("result moved during stall");
endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [IDX_W-1:0]  in_bitnum,
  input  logic              in_size_long,
  input  logic [1:0]        in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_zero,
  output logic              out_wb_en
);
  logic              srst_n;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] alu_result;
  logic              alu_zero, alu_wb;
  bmu_op_e           op;

  assign op = bmu_op_e'(in_op);

  bmu_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  bmu_index #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_idx (
    .bitnum    (in_bitnum),
    .size_long (in_size_long),
    .mask      (mask)
  );

  bmu_alu #(.DATA_W(DATA_W)) u_alu (
    .operand (in_operand),
    .mask    (mask),
    .op      (op),
    .result  (alu_result),
    .zero    (alu_zero),
    .wb_en   (alu_wb)
  );

  bmu_out_reg #(.DATA_W(DATA_W)) u_reg (
    .clk        (clk),
    .srst_n     (srst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .d_result   (alu_result),
    .d_zero     (alu_zero),
    .d_wb_en    (alu_wb),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .out_zero   (out_zero),
    .out_wb_en  (out_wb_en)
  );

  p_byte_upper_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_ready && !in_size_long) |=>
      (out_result[DATA_W-1:BYTE_W] == $past(in_operand[DATA_W-1:BYTE_W])))
    else $error("byte op touched upper bits");

  p_test_nowb_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_ready && in_op == 2'b00) |=>
      (!out_wb_en && out_result == $past(in_operand)))
    else $error("test op modified data");

  p_modify_wb_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_ready && in_op != 2'b00) |=> out_wb_en)
    else $error("modify op without write-back");

  p_reset_idle_r11: assert property (@(posedge clk)
    !srst_n |-> !out_valid)
    else $error("valid during reset");
endmodule

// File: tb/sim_bit_modify_unit.sv
module sim_bit_modify_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_size_long, out_valid, out_ready;
  logic        out_zero, out_wb_en;
  logic [31:0] in_operand, out_result;
  logic [4:0]  in_bitnum;
  logic [1:0]  in_op;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bit_modify_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_bitnum(in_bitnum), .in_size_long(in_size_long),
    .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_zero(out_zero), .out_wb_en(out_wb_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected {result, zero, wb} from the requirements.
  function automatic logic [33:0] model(input logic [1:0] op, input logic sz,
                                        input logic [4:0] bn, input logic [31:0] d);
    int idx = sz ? int'(bn) : int'(bn % 8);
    logic [31:0] r = d;
    case (op)
      2'b01: r[idx] = ~d[idx];
      2'b10: r[idx] = 1'b0;
      2'b11: r[idx] = 1'b1;
      default: r = d;
    endcase
    return {r, ~d[idx], op != 2'b00};
  endfunction

  task automatic drive(input logic [1:0] op, input logic sz, input logic [4:0] bn,
                       input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_size_long = sz; in_bitnum = bn; in_operand = d;
  endtask

  task automatic op_check(input string req, input logic [1:0] op, input logic sz,
                          input logic [4:0] bn, input logic [31:0] d);
    logic [33:0] e;
    e = model(op, sz, bn, d);
    drive(op, sz, bn, d);
    @(posedge clk); #1;
    chk({req, " valid"}, 64'(out_valid), 64'(1));
    chk({req, " result"}, 64'(out_result), 64'(e[33:2]));
    chk({req, " zero R2"}, 64'(out_zero), 64'(e[1]));
    chk({req, " wb"}, 64'(out_wb_en), 64'(e[0]));
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R9 idle drops valid", 64'(out_valid), 64'(0));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_op = '0; in_size_long = 1'b1; in_bitnum = '0; in_operand = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 valid in reset", 64'(out_valid), 64'(0));
    chk("R9 ready in reset", 64'(in_ready), 64'(1));
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 valid after release", 64'(out_valid), 64'(0));
  endtask

  task automatic t_test_op();
    op_check("R1 test bit0 set", 2'b00, 1'b1, 5'd0, 32'h0000_0001);
    op_check("R1 test bit31 clear", 2'b00, 1'b1, 5'd31, 32'h7FFF_FFFF);
    idle();
  endtask

  task automatic t_modify_ops();
    op_check("R3 set from 0", 2'b11, 1'b1, 5'd17, 32'h1234_5678);
    op_check("R3 set already 1", 2'b11, 1'b1, 5'd4, 32'h0000_0010);
    op_check("R4 clear from 1", 2'b10, 1'b1, 5'd30, 32'hFFFF_FFFF);
    op_check("R4 clear already 0", 2'b10, 1'b1, 5'd9, 32'h0000_0000);
    op_check("R5 flip 0", 2'b01, 1'b1, 5'd12, 32'hA5A5_A5A5);
    op_check("R5 flip 1", 2'b01, 1'b1, 5'd0, 32'hA5A5_A5A5);
    op_check("R8 wb on set", 2'b11, 1'b1, 5'd2, 32'h0);
    idle();
  endtask

  task automatic t_long_wrap();
    op_check("R6 long bit 31", 2'b01, 1'b1, 5'd31, 32'h0000_0000);
    op_check("R6 long bit 24", 2'b11, 1'b1, 5'd24, 32'h00FF_FFFF);
    idle();
  endtask

  task automatic t_byte_wrap();
    op_check("R7 byte bn13 -> bit5", 2'b11, 1'b0, 5'd13, 32'hFFFF_0000);
    op_check("R7 byte bn31 -> bit7", 2'b10, 1'b0, 5'd31, 32'hFFFF_FFFF);
    op_check("R7 byte flip bn8 -> bit0", 2'b01, 1'b0, 5'd8, 32'h8000_01FE);
    op_check("R7 byte test bn26", 2'b00, 1'b0, 5'd26, 32'h0400_0000);
    idle();
  endtask

  task automatic t_stall();
    logic [33:0] ea, eb;
    ea = model(2'b11, 1'b1, 5'd3, 32'h0000_0000);
    eb = model(2'b10, 1'b1, 5'd3, 32'hFFFF_FFFF);
    @(negedge clk); out_ready = 1'b0;
    drive(2'b11, 1'b1, 5'd3, 32'h0000_0000);
    @(posedge clk); #1;
    chk("R9 A accepted", 64'(out_result), 64'(ea[33:2]));
    chk("R9 ready low while stalled", 64'(in_ready), 64'(0));
    drive(2'b10, 1'b1, 5'd3, 32'hFFFF_FFFF);
    repeat (3) @(posedge clk);
    #1;
    chk("R10 valid held", 64'(out_valid), 64'(1));
    chk("R10 result held", 64'(out_result), 64'(ea[33:2]));
    chk("R10 flags held", 64'({out_zero, out_wb_en}), 64'(ea[1:0]));
    @(negedge clk); out_ready = 1'b1;
    #1;
    chk("R9 ready follows out_ready", 64'(in_ready), 64'(1));
    @(posedge clk); #1;
    chk("R9 B taken after stall", 64'(out_result), 64'(eb[33:2]));
    chk("R2 B zero", 64'(out_zero), 64'(eb[1]));
    idle();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_test_op();
    t_modify_ops();
    t_long_wrap();
    t_byte_wrap();
    t_stall();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule